// File: doc/BRIEF.md
# Driver Fault Supervisor with Latching

This block supervises a two-leg gate driver. It takes digital fault indications that analog comparators have already resolved: overtemperature, logic-supply good, regulator good, and a bootstrap charge timeout for each leg. It combines them into an active-low fault flag and a gate-disable signal. Each fault class follows its own rules. Overtemperature is reported but never blocks the gates. A logic-supply dropout wipes every stored fault and stands alone. Regulator dropout and bootstrap timeouts are held until something explicitly clears them.

The block also acts on the active-low reset input. It measures how long that input stays low. A pulse of at least `RES_MIN` cycles clears the latched faults. A low of `SLEEP_CYC` cycles puts the driver to sleep. On leaving sleep, and after the synchronous reset, the gates stay disabled for `WAKE_CYC` cycles while the charge pump settles. A rising edge on any high-side or low-side command input also clears a held regulator fault. All three outputs are registered and reflect the inputs sampled on the same clock edge.

Top module: `drv_fault_sup`

## Requirements
- R1: While `ot_hot` is 1 (and the block is awake and the logic supply is good), `fault_n` is 0 and overtemperature alone does not set `gate_dis`. When `ot_hot` returns to 0 the flag releases with no clear action.
- R2: While `vdd_ok` is 0 (awake), `fault_n` is 0 and `gate_dis` is 1. Both release as soon as `vdd_ok` returns to 1.
- R3: A sample with `vdd_ok` at 0 erases the held regulator fault and both held bootstrap faults. Once `vdd_ok` returns, the flag is high unless a fault input is still active.
- R4: A sample with `vreg_ok` at 0 sets a held regulator fault. It drives `fault_n` to 0 and `gate_dis` to 1, and it stays set after `vreg_ok` returns to 1.
- R5: A held regulator fault clears on the edge where any bit of `cmd_hi` or `cmd_lo` is sampled 1 after being sampled 0.
- R6: A sample with `boot_to[i]` at 1 sets a held bootstrap fault for leg i. It drives `fault_n` to 0 and `gate_dis` to 1. Command rising edges do not clear it.
- R7: On the `RES_MIN`-th consecutive sample of `reset_n_in` at 0, all held faults clear and the block stays awake. A low run shorter than `RES_MIN` samples has no effect.
- R8: On the `SLEEP_CYC`-th consecutive low sample, the block sleeps: `ready` is 0, `gate_dis` is 1 and `fault_n` is 1. No fault is held or reported while asleep.
- R9: After synchronous reset, `gate_dis` is 1 and `ready` is 0 for the first `WAKE_CYC - 1` edges, and `ready` rises on edge `WAKE_CYC`. When `reset_n_in` is first sampled high in sleep, the gates stay disabled for `WAKE_CYC` edges and `ready` rises on the next edge.
- R10: Under `rst`, the outputs are `fault_n`=1, `gate_dis`=1 and `ready`=0. Afterwards every output changes on the same edge that samples its cause.
- R11: A held regulator fault cannot be cleared while `vreg_ok` is still 0: setting wins over a simultaneous command edge or reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_n_in | input | 1 | Active-low clear / sleep request |
| ot_hot | input | 1 | Overtemperature indication, 1 = too hot |
| vdd_ok | input | 1 | Logic supply above threshold |
| vreg_ok | input | 1 | Regulator above threshold |
| boot_to | input | NLEG | Bootstrap charge timeout per leg |
| cmd_hi | input | NLEG | High-side command per leg |
| cmd_lo | input | NLEG | Low-side command per leg |
| fault_n | output | 1 | Fault flag, 0 = any active fault |
| gate_dis | output | 1 | 1 = all gate drives forced off |
| ready | output | 1 | 1 = awake and past the wake-up hold-off |

## Verification
The bench targets the edges of the reset-pulse timer. A low run one cycle short of `RES_MIN` must leave a held fault intact. A run of exactly `RES_MIN` must clear it without sleep; a design that counts off by one clears too early or too late. The bench also raises a command edge while the regulator is still bad, which catches a design that lets clearing win over setting. It checks that a bootstrap fault survives command edges and that a logic-supply dropout wipes held faults. The last step holds the wake-up window to its exact length, where an off-by-one counter or a missing hold-off would show `ready` on the wrong edge.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  typedef struct packed {
    logic flag_n;
    logic dis;
    logic rdy;
  } sup_out_t;

  localparam sup_out_t SUP_OUT_RST = '{flag_n: 1'b1, dis: 1'b1, rdy: 1'b0};
endpackage

// File: rtl/cmd_rise_det.sv
module cmd_rise_det #(
  parameter int NLEG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLEG-1:0] cmd_hi,
  input  logic [NLEG-1:0] cmd_lo,
  output logic            rise_any
);
  logic [NLEG-1:0] rise_hi, rise_lo;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic hi_q, lo_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else begin
        hi_q <= cmd_hi[g];
        lo_q <= cmd_lo[g];
      end
    end
    assign rise_hi[g] = cmd_hi[g] & ~hi_q;
    assign rise_lo[g] = cmd_lo[g] & ~lo_q;
  end

  assign rise_any = |{rise_hi, rise_lo};
endmodule

// File: rtl/rst_pulse_timer.sv
module rst_pulse_timer #(
  parameter int RES_MIN   = 8,
  parameter int SLEEP_CYC = 64,
  parameter int WAKE_CYC  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic reset_n_in,
  output logic clr_now,
  output logic sleep_nx,
  output logic hold_nx,
  output logic asleep_q
);
  localparam int LW = $clog2(SLEEP_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic [LW-1:0] low_q, low_nx;
  logic [WW-1:0] wake_q, wake_nx;

  always_comb begin
    if (reset_n_in)                     low_nx = '0;
    else if (low_q == LW'(SLEEP_CYC))   low_nx = low_q;
    else                                low_nx = low_q + 1'b1;
  end

  assign clr_now  = ~reset_n_in && (low_nx == LW'(RES_MIN));
  assign sleep_nx = ~reset_n_in && (low_nx == LW'(SLEEP_CYC));

  always_comb begin
    if (sleep_nx)            wake_nx = '0;
    else if (asleep_q)       wake_nx = WW'(WAKE_CYC);
    else if (wake_q != '0)   wake_nx = wake_q - 1'b1;
    else                     wake_nx = wake_q;
  end

  assign hold_nx = (wake_nx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q    <= '0;
      wake_q   <= WW'(WAKE_CYC);
      asleep_q <= 1'b0;
    end else begin
      low_q    <= low_nx;
      wake_q   <= wake_nx;
      asleep_q <= sleep_nx;
    end
  end
endmodule

// File: rtl/fault_latch_core.sv
module fault_latch_core
  import drv_fault_pkg::*;
#(
  parameter int NLEG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ot_hot,
  input  logic            vdd_ok,
  input  logic            vreg_ok,
  input  logic [NLEG-1:0] boot_to,
  input  logic            rise_any,
  input  logic            clr_now,
  input  logic            sleep_nx,
  input  logic            hold_nx,
  output sup_out_t        out_q,
  output logic            vreg_q,
  output logic [NLEG-1:0] boot_q
);
  logic            kill;
  logic            vreg_nx;
  logic [NLEG-1:0] boot_nx;
  logic            held_any;
  sup_out_t        out_nx;

  assign kill = ~vdd_ok | sleep_nx;

  always_comb begin
    if (kill)                     vreg_nx = 1'b0;
    else if (~vreg_ok)            vreg_nx = 1'b1;
    else if (rise_any | clr_now)  vreg_nx = 1'b0;
    else                          vreg_nx = vreg_q;
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_boot
    always_comb begin
      if (kill)            boot_nx[g] = 1'b0;
      else if (boot_to[g]) boot_nx[g] = 1'b1;
      else if (clr_now)    boot_nx[g] = 1'b0;
      else                 boot_nx[g] = boot_q[g];
    end
  end

  assign held_any = vreg_nx | (|boot_nx);

  always_comb begin
    out_nx.flag_n = sleep_nx | ~(ot_hot | ~vdd_ok | held_any);
    out_nx.dis    = sleep_nx | hold_nx | ~vdd_ok | held_any;
    out_nx.rdy    = ~sleep_nx & ~hold_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vreg_q <= 1'b0;
      boot_q <= '0;
      out_q  <= SUP_OUT_RST;
    end else begin
      vreg_q <= vreg_nx;
      boot_q <= boot_nx;
      out_q  <= out_nx;
    end
  end
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup
  import drv_fault_pkg::*;
#(
  parameter int NLEG      = 2,
  parameter int RES_MIN   = 8,
  parameter int SLEEP_CYC = 64,
  parameter int WAKE_CYC  = 100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reset_n_in,
  input  logic            ot_hot,
  input  logic            vdd_ok,
  input  logic            vreg_ok,
  input  logic [NLEG-1:0] boot_to,
  input  logic [NLEG-1:0] cmd_hi,
  input  logic [NLEG-1:0] cmd_lo,
  output logic            fault_n,
  output logic            gate_dis,
  output logic            ready
);
  logic            rise_any, clr_now, sleep_nx, hold_nx, asleep_q;
  logic            vreg_q;
  logic [NLEG-1:0] boot_q;
  sup_out_t        out_q;

  cmd_rise_det #(.NLEG(NLEG)) u_edge (
    .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .rise_any(rise_any)
  );

  rst_pulse_timer #(.RES_MIN(RES_MIN), .SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .reset_n_in(reset_n_in), .clr_now(clr_now),
    .sleep_nx(sleep_nx), .hold_nx(hold_nx), .asleep_q(asleep_q)
  );

  fault_latch_core #(.NLEG(NLEG)) u_core (
    .clk(clk), .rst(rst), .ot_hot(ot_hot), .vdd_ok(vdd_ok), .vreg_ok(vreg_ok),
    .boot_to(boot_to), .rise_any(rise_any), .clr_now(clr_now), .sleep_nx(sleep_nx),
    .hold_nx(hold_nx), .out_q(out_q), .vreg_q(vreg_q), .boot_q(boot_q)
  );

  assign fault_n  = out_q.flag_n;
  assign gate_dis = out_q.dis;
  assign ready    = out_q.rdy;
endmodule

// File: rtl/drv_fault_sup_chk.sv
module drv_fault_sup_chk #(
  parameter int NLEG = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            ot_hot,
  input logic            vdd_ok,
  input logic            fault_n,
  input logic            gate_dis,
  input logic            ready,
  input logic            rise_any,
  input logic            clr_now,
  input logic            sleep_nx,
  input logic            asleep_q,
  input logic            vreg_q,
  input logic [NLEG-1:0] boot_q
);
  AST_OT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (ot_hot && vdd_ok && !sleep_nx) |=> !fault_n); // R1

  AST_VDD_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (!vdd_ok && !sleep_nx) |=> (!fault_n && gate_dis)); // R2

  AST_VDD_WIPES: assert property (@(posedge clk) disable iff (rst)
    !vdd_ok |=> (!vreg_q && boot_q == '0)); // R3

  AST_VREG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (vreg_q && vdd_ok && !rise_any && !clr_now && !sleep_nx) |=> vreg_q); // R4

  AST_SLEEP_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    asleep_q |-> (!ready && gate_dis && fault_n)); // R8

  AST_HOLDOFF_DISABLES: assert property (@(posedge clk) disable iff (rst)
    !ready |-> gate_dis); // R9
endmodule

bind drv_fault_sup drv_fault_sup_chk #(.NLEG(NLEG)) u_chk (
  .clk(clk), .rst(rst), .ot_hot(ot_hot), .vdd_ok(vdd_ok), .fault_n(fault_n),
  .gate_dis(gate_dis), .ready(ready), .rise_any(rise_any), .clr_now(clr_now),
  .sleep_nx(sleep_nx), .asleep_q(asleep_q), .vreg_q(vreg_q), .boot_q(boot_q)
);

// File: tb/drv_fault_sup_test.sv
`timescale 1ns/1ps
module drv_fault_sup_test;
  localparam int NLEG = 2, RMIN = 4, SLP = 16, WK = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic rn = 1'b1, ot = 1'b0, vdd = 1'b1, vreg = 1'b1;
  logic [NLEG-1:0] bto = '0, chi = '0, clo = '0;
  logic fault_n, gate_dis, ready;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  drv_fault_sup #(.NLEG(NLEG), .RES_MIN(RMIN), .SLEEP_CYC(SLP), .WAKE_CYC(WK)) uut (
    .clk(clk), .rst(rst), .reset_n_in(rn), .ot_hot(ot), .vdd_ok(vdd), .vreg_ok(vreg),
    .boot_to(bto), .cmd_hi(chi), .cmd_lo(clo),
    .fault_n(fault_n), .gate_dis(gate_dis), .ready(ready)
  );

  typedef struct {
    bit    chk;
    logic  fn, dis, rdy;
    string tag;
  } exp_t;
  exp_t sb[$];
  exp_t cur;

  function automatic void compare(logic fn, logic dis, logic rdy, string tag);
    n_chk++;
    if (fault_n !== fn || gate_dis !== dis || ready !== rdy) begin
      n_fail++;
      $display("FAIL %s: got fault_n=%b gate_dis=%b ready=%b, expected %b %b %b",
               tag, fault_n, gate_dis, ready, fn, dis, rdy);
    end
  endfunction

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      if (cur.chk) compare(cur.fn, cur.dis, cur.rdy, cur.tag);
    end
  end

  task automatic cyc(bit chk, logic fn, logic dis, logic rdy, string tag);
    exp_t e;
    e.chk = chk; e.fn = fn; e.dis = dis; e.rdy = rdy; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b1, 1'b1, 1'b0, "R10 reset state");
    rst = 1'b0;
    // R9 startup hold-off
    for (int i = 1; i < WK; i++) cyc(1, 1, 1, 0, "R9 startup hold");
    cyc(1, 1, 0, 1, "R9 startup ready");
    // R1 overtemperature
    ot = 1; cyc(1, 0, 0, 1, "R1 ot flags no disable");
    ot = 0; cyc(1, 1, 0, 1, "R1 ot releases");
    // R2 logic supply
    vdd = 0; cyc(1, 0, 1, 1, "R2 vdd uv");
    vdd = 1; cyc(1, 1, 0, 1, "R2 vdd recovers");
    // R4 regulator latched
    vreg = 0; cyc(1, 0, 1, 1, "R4 vreg set");
    vreg = 1;
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, "R4 vreg held");
    chi[0] = 1; cyc(1, 1, 0, 1, "R5 clear by hi edge");
    cyc(1, 1, 0, 1, "R5 level no refault");
    // R11 set dominates
    chi[0] = 0; vreg = 0; cyc(1, 0, 1, 1, "R11 vreg set");
    chi[0] = 1; cyc(1, 0, 1, 1, "R11 edge while bad");
    vreg = 1; cyc(1, 0, 1, 1, "R11 still held");
    clo[1] = 1; cyc(1, 1, 0, 1, "R5 clear by lo edge");
    chi[0] = 0; clo[1] = 0; cyc(1, 1, 0, 1, "R5 idle");
    // R6 bootstrap
    bto[1] = 1; cyc(1, 0, 1, 1, "R6 boot set");
    bto[1] = 0; cyc(1, 0, 1, 1, "R6 boot held");
    chi[1] = 1; cyc(1, 0, 1, 1, "R6 edge ignored");
    chi[1] = 0; cyc(0, 0, 0, 0, "");
    // R7 short pulse ignored, then valid pulse
    rn = 0;
    for (int i = 0; i < RMIN - 1; i++) cyc(1, 0, 1, 1, "R7 short low");
    rn = 1; cyc(1, 0, 1, 1, "R7 short ignored");
    rn = 0;
    for (int i = 0; i < RMIN - 1; i++) cyc(1, 0, 1, 1, "R7 counting");
    cyc(1, 1, 0, 1, "R7 clear at min width");
    rn = 1; cyc(1, 1, 0, 1, "R7 awake after clear");
    // R3 logic supply wipes latched faults
    vreg = 0; cyc(1, 0, 1, 1, "R3 vreg set");
    vreg = 1; bto[0] = 1; cyc(1, 0, 1, 1, "R3 boot set");
    bto[0] = 0; vdd = 0; cyc(1, 0, 1, 1, "R3 vdd uv");
    vdd = 1; cyc(1, 1, 0, 1, "R3 wiped");
    // R8 sleep
    vreg = 0; cyc(1, 0, 1, 1, "R8 pre fault");
    vreg = 1; rn = 0;
    for (int i = 1; i < RMIN; i++) cyc(1, 0, 1, 1, "R8 low pre clear");
    for (int i = RMIN; i < SLP; i++) cyc(1, 1, 0, 1, "R8 cleared awake");
    cyc(1, 1, 1, 0, "R8 enter sleep");
    vreg = 0; ot = 1;
    cyc(1, 1, 1, 0, "R8 faults masked");
    cyc(1, 1, 1, 0, "R8 faults masked");
    vreg = 1; ot = 0; cyc(1, 1, 1, 0, "R8 asleep");
    // R9 wake hold-off
    rn = 1;
    for (int i = 0; i < WK; i++) cyc(1, 1, 1, 0, "R9 wake hold");
    cyc(1, 1, 0, 1, "R9 wake ready");
    cyc(1, 1, 0, 1, "R8 nothing latched in sleep");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule